// File: doc/BRIEF.md
# Stack Guard Window Write Monitor

This block watches every access on a memory bus and flags any write that touches a single protected window of memory. The window is meant to sit at the bottom of the running task's stack, so that a stack that grows too far is caught the moment it writes into the protected area. On every task switch the context-switch logic moves the window to the stack of the incoming task. It does this by writing a new base address and a size code.

The window size is a power of two of at least 32 bytes, and the base must be aligned to that size. A configuration that breaks either rule is refused: the window that was active stays in force and an error pulse is raised. The window may be placed just below the stack or inside the bottom of the stack. In the second case it takes space away from the usable stack; for example, a 64-byte window uses one eighth of a 512-byte stack.

A violating write raises a combinational fault in the same cycle it appears on the bus. A sticky flag records that a fault happened, and the address of the first faulting write is kept for the handler.

Top module: `guard_window_monitor`

## Requirements
- R1: A write whose start address lies inside the active window drives `fault` high in the same cycle as the write.
- R2: A write covers 2^`wr_size` bytes starting at `wr_addr` (`wr_size` 0..3 gives 1, 2, 4 or 8 bytes). It faults when any of those bytes falls in the window, including a write that starts below the window and ends inside it.
- R3: Reads (`wr_write` low) never fault. Writes whose whole byte range lies outside the window do not fault.
- R4: While no configuration has been accepted since reset, no access faults.
- R5: `cfg_code` is log2 of the window size in bytes. A configuration write with a code below 5 is refused: `cfg_err` is high for exactly the following cycle and the previous window stays active.
- R6: A configuration write whose base is not a multiple of the window size is refused: `cfg_err` is high for exactly the following cycle and the previous window stays active.
- R7: An accepted configuration write replaces the window starting with the next cycle. `cfg_err` stays low after it.
- R8: `fault_sticky` goes high in the cycle after the first fault and stays high until reset.
- R9: `fault_addr` holds the start address of the first faulting write, from the cycle after that write until reset. Later faults do not change it.
- R10: After reset, `fault`, `fault_sticky`, `fault_addr` and `cfg_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe from the context-switch logic |
| cfg_base | input | 32 | Window base address |
| cfg_code | input | 5 | Window size as log2(bytes) |
| wr_valid | input | 1 | Bus access valid |
| wr_write | input | 1 | Access is a write (low means read) |
| wr_addr | input | 32 | Access start address |
| wr_size | input | 2 | Access size as log2(bytes) |
| fault | output | 1 | Guard violation, same cycle as the access |
| fault_sticky | output | 1 | A violation has occurred since reset |
| fault_addr | output | 32 | Start address of the first violating write |
| cfg_err | output | 1 | One-cycle pulse after a refused configuration |

## Verification
A corrupted window base or size shows up at the ports in the first write probe near the window edge. Faults then appear at the wrong addresses in the same cycle as the write. A refused configuration that still overwrote the window shows up through the next write to the old window, which no longer faults. Errors in the sticky flag or the captured address become visible one cycle after the first fault, and they stay visible because later faults must leave both unchanged.

// File: rtl/guard_window_pkg.sv
package guard_window_pkg;

    localparam int ADDR_W = 32;
    localparam int CODE_W = 5;
    localparam int ACC_W  = 2;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] base;
        logic [CODE_W-1:0] code;
    } guard_win_t;

    // Mask of the offset bits inside a window of 2^code bytes
    function automatic logic [ADDR_W-1:0] low_mask(input logic [CODE_W-1:0] code);
        return (ADDR_W'(1) << code) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/guard_cfg_reg.sv
module guard_cfg_reg
    import guard_window_pkg::*;
#(
    parameter int MIN_CODE = 5,
    parameter int MAX_CODE = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CODE_W-1:0] cfg_code,
    output guard_win_t        win,
    output logic              cfg_err
);

    logic code_bad;
    logic align_bad;
    logic refuse;

    always_comb begin
        code_bad  = (cfg_code < CODE_W'(MIN_CODE)) || (cfg_code > CODE_W'(MAX_CODE));
        align_bad = (cfg_base & low_mask(cfg_code)) != '0;
        refuse    = code_bad || align_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win     <= '0;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= cfg_we && refuse;
            if (cfg_we && !refuse) begin
                win.valid <= 1'b1;
                win.base  <= cfg_base;
                win.code  <= cfg_code;
            end
        end
    end

endmodule

// File: rtl/guard_hit_detect.sv
module guard_hit_detect
    import guard_window_pkg::*;
(
    input  guard_win_t        win,
    input  logic              wr_valid,
    input  logic              wr_write,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_size,
    output logic              hit
);

    localparam int XW    = ADDR_W + 1;
    localparam int N_END = 2;

    logic [XW-1:0]    ends [N_END];
    logic [XW-1:0]    hi_mask;
    logic [XW-1:0]    base_x;
    logic [N_END-1:0] end_hit;

    // First and last byte of the access. The window is never smaller than
    // the largest access, so checking both ends covers every overlap.
    always_comb begin
        ends[0] = {1'b0, wr_addr};
        ends[1] = {1'b0, wr_addr} + (XW'(1) << wr_size) - XW'(1);
        hi_mask = {1'b1, ~low_mask(win.code)};
        base_x  = {1'b0, win.base};
    end

    for (genvar e = 0; e < N_END; e++) begin : g_end
        assign end_hit[e] = ((ends[e] ^ base_x) & hi_mask) == '0;
    end

    assign hit = wr_valid && wr_write && win.valid && (|end_hit);

endmodule

// File: rtl/guard_fault_log.sv
module guard_fault_log
    import guard_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              sticky,
    output logic [ADDR_W-1:0] first_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky     <= 1'b0;
            first_addr <= '0;
        end else if (hit && !sticky) begin
            sticky     <= 1'b1;
            first_addr <= wr_addr;
        end
    end

endmodule

// File: rtl/guard_window_monitor.sv
module guard_window_monitor
    import guard_window_pkg::*;
#(
    parameter int MIN_CODE = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              wr_valid,
    input  logic              wr_write,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_size,
    output logic              fault,
    output logic              fault_sticky,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              cfg_err
);

    guard_win_t win;

    guard_cfg_reg #(.MIN_CODE(MIN_CODE)) cfg_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_base (cfg_base),
        .cfg_code (cfg_code),
        .win      (win),
        .cfg_err  (cfg_err)
    );

    guard_hit_detect hit_i (
        .win      (win),
        .wr_valid (wr_valid),
        .wr_write (wr_write),
        .wr_addr  (wr_addr),
        .wr_size  (wr_size),
        .hit      (fault)
    );

    guard_fault_log log_i (
        .clk        (clk),
        .rst        (rst),
        .hit        (fault),
        .wr_addr    (wr_addr),
        .sticky     (fault_sticky),
        .first_addr (fault_addr)
    );

endmodule

// File: rtl/guard_window_monitor_chk.sv
module guard_window_monitor_chk
    import guard_window_pkg::*;
#(
    parameter int MIN_CODE = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [CODE_W-1:0] cfg_code,
    input logic              wr_valid,
    input logic              wr_write,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              fault,
    input logic              fault_sticky,
    input logic [ADDR_W-1:0] fault_addr,
    input logic              cfg_err,
    input guard_win_t        win
);

    a_r3_read_no_fault: assert property (@(posedge clk) disable iff (rst)
        fault |-> (wr_valid && wr_write));

    a_r4_no_window: assert property (@(posedge clk) disable iff (rst)
        !win.valid |-> !fault);

    a_r5_small_code: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_code < CODE_W'(MIN_CODE)) |=> (cfg_err && $stable(win)));

    a_r6_misaligned: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_code >= CODE_W'(MIN_CODE) && (cfg_base & low_mask(cfg_code)) != '0)
        |=> (cfg_err && $stable(win)));

    a_r7_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> !cfg_err);

    a_r8_sticky_set: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault_sticky);

    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        fault_sticky |=> fault_sticky);

    a_r9_addr_capture: assert property (@(posedge clk) disable iff (rst)
        (fault && !fault_sticky) |=> (fault_addr == $past(wr_addr)));

    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        fault_sticky |=> $stable(fault_addr));

endmodule

bind guard_window_monitor guard_window_monitor_chk #(.MIN_CODE(MIN_CODE)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_base     (cfg_base),
    .cfg_code     (cfg_code),
    .wr_valid     (wr_valid),
    .wr_write     (wr_write),
    .wr_addr      (wr_addr),
    .fault        (fault),
    .fault_sticky (fault_sticky),
    .fault_addr   (fault_addr),
    .cfg_err      (cfg_err),
    .win          (win)
);

// File: tb/guard_window_monitor_tb_top.sv
module guard_window_monitor_tb_top;
    import guard_window_pkg::*;

    typedef struct {
        logic              fault;
        logic              sticky;
        logic [ADDR_W-1:0] addr;
        logic              err;
        string             tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [CODE_W-1:0] cfg_code = '0;
    logic              wr_valid = 1'b0;
    logic              wr_write = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [ACC_W-1:0]  wr_size = '0;
    logic              fault, fault_sticky, cfg_err;
    logic [ADDR_W-1:0] fault_addr;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];

    // reference state, derived from the requirements
    logic              m_valid = 1'b0;
    logic [ADDR_W-1:0] m_base = '0;
    int                m_bytes = 0;
    logic              m_sticky = 1'b0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic              m_err = 1'b0;

    always #5 clk = ~clk;

    guard_window_monitor dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_code(cfg_code),
        .wr_valid(wr_valid), .wr_write(wr_write), .wr_addr(wr_addr), .wr_size(wr_size),
        .fault(fault), .fault_sticky(fault_sticky), .fault_addr(fault_addr), .cfg_err(cfg_err)
    );

    function automatic logic model_hit(logic [ADDR_W-1:0] a, int n);
        for (int i = 0; i < n; i++) begin
            longint unsigned b = longint'(a) + longint'(i);
            if (m_valid && b >= longint'(m_base) && b < longint'(m_base) + longint'(m_bytes))
                return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic step(input logic we, input logic [ADDR_W-1:0] cb, input int cc,
                        input logic v, input logic w, input logic [ADDR_W-1:0] a,
                        input int sz, input string tag);
        exp_t e;
        logic hit;
        logic bad;
        @(posedge clk);
        #1;
        cfg_we = we; cfg_base = cb; cfg_code = CODE_W'(cc);
        wr_valid = v; wr_write = w; wr_addr = a; wr_size = ACC_W'(sz);
        hit = v && w && model_hit(a, 1 << sz);
        e.fault = hit; e.sticky = m_sticky; e.addr = m_addr; e.err = m_err; e.tag = tag;
        sb.push_back(e);
        if (hit && !m_sticky) begin
            m_sticky = 1'b1;
            m_addr   = a;
        end
        bad = we && ((cc < 5) || ((cb % (ADDR_W'(1) << cc)) != 0));
        if (we && !bad) begin
            m_valid = 1'b1; m_base = cb; m_bytes = 1 << cc;
        end
        m_err = bad;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input int sz, input string tag);
        step(1'b0, '0, 0, 1'b1, 1'b1, a, sz, tag);
    endtask

    task automatic cfg(input logic [ADDR_W-1:0] b, input int c, input string tag);
        step(1'b1, b, c, 1'b0, 1'b0, '0, 0, tag);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; cfg_we = 1'b0; wr_valid = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        m_valid = 1'b0; m_sticky = 1'b0; m_addr = '0; m_err = 1'b0;
        @(negedge clk);
        checks++;
        if (fault || fault_sticky || fault_addr != '0 || cfg_err) begin
            errors++;
            $display("FAIL R10 reset state: fault=%0b sticky=%0b addr=%h err=%0b expected all 0",
                     fault, fault_sticky, fault_addr, cfg_err);
        end
    endtask

    // monitor: compares each expected item against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (fault !== e.fault || fault_sticky !== e.sticky ||
                    fault_addr !== e.addr || cfg_err !== e.err) begin
                    errors++;
                    $display("FAIL %s: fault=%0b sticky=%0b addr=%h err=%0b expected fault=%0b sticky=%0b addr=%h err=%0b",
                             e.tag, fault, fault_sticky, fault_addr, cfg_err,
                             e.fault, e.sticky, e.addr, e.err);
                end
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();                                   // R10
        wr(32'h0000_1000, 0, "R4 write with no window");
        wr(32'h0000_0000, 3, "R4 write at zero, no window");
        // 64-byte window at 0x1000; a write in the same cycle is not yet covered
        step(1'b1, 32'h0000_1000, 6, 1'b1, 1'b1, 32'h0000_1000, 0, "R7 same-cycle write");
        wr(32'h0000_1000, 0, "R1 first byte");
        wr(32'h0000_103F, 0, "R1 last byte");
        wr(32'h0000_1040, 0, "R3 just above");
        wr(32'h0000_0FFF, 0, "R3 just below");
        wr(32'h0000_0FFC, 2, "R2 word ending below");
        wr(32'h0000_0FFE, 2, "R2 word straddling");
        wr(32'h0000_0FF8, 3, "R2 dword ending below");
        wr(32'h0000_0FF9, 3, "R2 dword last byte in window");
        wr(32'h0000_103C, 3, "R2 dword straddling top");
        step(1'b0, '0, 0, 1'b1, 1'b0, 32'h0000_1010, 0, "R3 read inside");
        cfg(32'h0000_2000, 4, "R5 code 4 refused");
        wr(32'h0000_1010, 0, "R5 old window kept");
        wr(32'h0000_2000, 0, "R5 refused window inactive");
        cfg(32'h0000_2010, 6, "R6 misaligned refused");
        wr(32'h0000_2010, 0, "R6 refused window inactive");
        wr(32'h0000_1020, 1, "R6 old window kept");
        cfg(32'h0000_2000, 5, "R7 move to 32-byte window");
        wr(32'h0000_1000, 0, "R7 old window released");
        wr(32'h0000_201F, 0, "R7 new window top byte");
        wr(32'h0000_2020, 0, "R7 above new window");
        cfg(32'h0000_2100, 8, "R7 256-byte window");
        wr(32'h0000_21FF, 0, "R9 later fault keeps address");
        wr(32'h0000_2200, 0, "R8 sticky holds");
        do_reset();                                   // R10 again
        wr(32'h0000_2100, 0, "R4 window cleared by reset");
        cfg(32'h0000_4000, 7, "R7 window after reset");
        wr(32'h0000_407E, 1, "R8 fault after reset");
        wr(32'h0000_4000, 0, "R9 captured first address");
        wr(32'h0000_0000, 0, "R9 final");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule